// File: doc/BRIEF.md
# Card Command Response Capture

This block issues one storage-card command at a time and collects what the card sends back. Software loads a 6-bit command index and a 32-bit argument, then writes a mode word. The mode word selects the expected response kind and whether a data transfer follows. The command starts at once if the card clock is running. If the clock is stopped, it starts on the next clock-start request. The card model answers with a stream of bytes, then a completion strobe carrying the total byte count.

On completion the block compares the count with the minimum that the selected response kind needs. A long enough answer is kept in a nine-entry queue of halfwords, which software drains through one register address that steps forward on each read. A short answer raises a response-timeout flag and leaves the queue empty. When the mode word asks for data and the answer is good, the block hands the data path a byte total equal to block count times block length.

Register map (4-bit `reg_addr`, 16-bit data): 0 control (write bit 0 = start clock, bit 1 = stop clock), 1 status, 2 mode, 3 block length, 4 block count, 5 interrupt request, 6 command index, 7 argument upper half, 8 argument lower half, 9 response queue. Status bits: 1 = response timeout, 8 = clock running, 13 = response received. Mode bits: [1:0] response kind, 2 = data follows, 10 = hold (do not start). Interrupt request bit 2 = command ended.

Top module: `card_resp_capture`

## Requirements
- R1: After reset the clock is stopped, status and interrupt request read 0, `busy` and `op_active` are low, and the response address reads 0.
- R2: The index register keeps 6 bits and reads back as the index ORed with 0x40. Each argument half is written on its own without changing the other half, and `card_index`/`card_arg` carry both halves when `card_launch` pulses.
- R3: A mode write stores the data ANDed with 0x3dff. If the clock is running and mode bit 10 is clear, `card_launch` is high for exactly the one cycle after the write.
- R4: Control bit 1 stops the clock and takes precedence over bit 0 in the same write. It also drops `op_active`. A mode write made while the clock is stopped starts nothing. A later control write with bit 0 starts it, unless mode bit 10 is set. Status bit 8 shows the clock state.
- R5: The minimum response byte count is 0 for kind 0, 4 for kind 1, 16 for kind 2 and 4 for kind 3.
- R6: A count below the minimum sets status bit 1, leaves bit 13 clear, leaves every response read at 0 and drops `op_active`.
- R7: A count at or above the minimum sets status bit 13. Response byte 2k is placed in bits [7:0] of entry k and byte 2k+1 in bits [15:8]. Reading restarts at entry 0.
- R8: Each response read returns the next entry. After the ninth entry, reads return 0.
- R9: Every completed command sets interrupt request bit 2, and the next launch clears it.
- R10: A good answer with mode bit 2 set pulses `data_arm` for one cycle with `data_bytes` equal to block count times block length and keeps `op_active` high. Without bit 2, `op_active` is low after completion.
- R11: `busy` is high from launch until the completion strobe. Mode writes and clock-start launches made while `busy` is high are ignored, and the mode register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the response queue) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| card_launch | output | 1 | One-cycle command start to the card |
| card_index | output | IDX_W | Command index |
| card_arg | output | 32 | Command argument |
| card_byte_vld | input | 1 | Response byte valid |
| card_byte | input | 8 | Response byte |
| card_done | input | 1 | Response finished, count valid |
| card_count | input | CNT_W | Number of response bytes |
| busy | output | 1 | Command in flight |
| op_active | output | 1 | Operation active (held while data is pending) |
| data_arm | output | 1 | One-cycle data path start |
| data_bytes | output | BLKLEN_W+NUMBLK_W | Data byte total |

## Verification
The bench builds the block with its default parameters: a nine-entry queue, 5-bit byte count, 6-bit index, 12-bit block length and 16-bit block count. With these values a 16-byte long answer fills eight entries, so the ninth read and every read past the end show 0. The 16-bit block count and 12-bit block length give a data total wide enough to check an arm value of 0x600. The 5-bit count also reaches every response minimum, so both a short and an exact answer can be driven for each response kind.

// File: rtl/cardresp_pkg.sv
package cardresp_pkg;

  localparam int REG_W = 16;

  typedef enum logic [3:0] {
    SEL_CTRL   = 4'd0,
    SEL_STATUS = 4'd1,
    SEL_MODE   = 4'd2,
    SEL_BLKLEN = 4'd3,
    SEL_NUMBLK = 4'd4,
    SEL_IREQ   = 4'd5,
    SEL_INDEX  = 4'd6,
    SEL_ARG_HI = 4'd7,
    SEL_ARG_LO = 4'd8,
    SEL_RESP   = 4'd9
  } reg_sel_e;

  localparam logic [REG_W-1:0] MODE_MASK = 16'h3dff;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_STOP_BIT  = 1;
  localparam int MODE_DATA_BIT  = 2;
  localparam int MODE_HOLD_BIT  = 10;
  localparam int ST_TOUT_BIT    = 1;
  localparam int ST_CLK_BIT     = 8;
  localparam int ST_RESP_BIT    = 13;
  localparam int IREQ_CMD_BIT   = 2;
  localparam int INDEX_TAG      = 16'h0040;

  // minimum byte count for each response kind
  function automatic int min_resp_bytes(input logic [1:0] kind);
    case (kind)
      2'd0:    return 0;
      2'd2:    return 16;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/cardresp_queue.sv
module cardresp_queue #(
  parameter int DEPTH = 9,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             rewind,
  input  logic             rd_adv,
  output logic [15:0]      rd_data
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][15:0] q_q, q_d;
  logic [PW-1:0]          ptr_q, ptr_d;

  always_comb begin
    q_d   = q_q;
    ptr_d = ptr_q;
    if (clr) begin
      q_d = '0;
    end else if (wr) begin
      if (wr_idx[0]) q_d[wr_idx[AW:1]][15:8] = wr_byte;
      else           q_d[wr_idx[AW:1]][7:0]  = wr_byte;
    end
    if (rewind) begin
      ptr_d = '0;
    end else if (rd_adv && (ptr_q < PW'(DEPTH))) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      ptr_q <= PW'(DEPTH);
    end else begin
      q_q   <= q_d;
      ptr_q <= ptr_d;
    end
  end

  assign rd_data = (ptr_q < PW'(DEPTH)) ? q_q[ptr_q[AW-1:0]] : 16'h0000;

endmodule

// File: rtl/cardresp_regs.sv
module cardresp_regs
  import cardresp_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int BLKLEN_W = 12,
  parameter int NUMBLK_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [3:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                busy,
  output logic                clk_on,
  output logic [REG_W-1:0]    mode,
  output logic [BLKLEN_W-1:0] blklen,
  output logic [NUMBLK_W-1:0] numblk,
  output logic [IDX_W-1:0]    cmd_idx,
  output logic [2*REG_W-1:0]  arg,
  output logic                launch_req,
  output logic                mode_wr,
  output logic                clk_stop
);

  logic                clk_on_q, clk_on_d;
  logic [REG_W-1:0]    mode_q, mode_d;
  logic [BLKLEN_W-1:0] blklen_q, blklen_d;
  logic [NUMBLK_W-1:0] numblk_q, numblk_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [2*REG_W-1:0]  arg_q, arg_d;
  logic                pend_q, pend_d;
  logic                start_evt;

  always_comb begin
    clk_on_d   = clk_on_q;
    mode_d     = mode_q;
    blklen_d   = blklen_q;
    numblk_d   = numblk_q;
    idx_d      = idx_q;
    arg_d      = arg_q;
    pend_d     = pend_q;
    launch_req = 1'b0;

    mode_wr   = reg_wr && (reg_addr == SEL_MODE) && !busy;
    clk_stop  = reg_wr && (reg_addr == SEL_CTRL) && reg_wdata[CTRL_STOP_BIT];
    start_evt = reg_wr && (reg_addr == SEL_CTRL) && reg_wdata[CTRL_START_BIT]
                && !reg_wdata[CTRL_STOP_BIT];

    // stop wins over start in the same write
    if (clk_stop)       clk_on_d = 1'b0;
    else if (start_evt) clk_on_d = 1'b1;

    if (mode_wr) begin
      mode_d = reg_wdata & MODE_MASK;
      pend_d = 1'b1;
      if (clk_on_q && !reg_wdata[MODE_HOLD_BIT]) begin
        launch_req = 1'b1;
        pend_d     = 1'b0;
      end
    end

    if (start_evt && pend_q && !mode_q[MODE_HOLD_BIT] && !busy) begin
      launch_req = 1'b1;
      pend_d     = 1'b0;
    end

    if (reg_wr) begin
      case (reg_addr)
        SEL_BLKLEN: blklen_d = reg_wdata[BLKLEN_W-1:0];
        SEL_NUMBLK: numblk_d = reg_wdata[NUMBLK_W-1:0];
        SEL_INDEX:  idx_d    = reg_wdata[IDX_W-1:0];
        SEL_ARG_HI: arg_d[2*REG_W-1:REG_W] = reg_wdata;
        SEL_ARG_LO: arg_d[REG_W-1:0]       = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_on_q <= 1'b0;
      mode_q   <= '0;
      blklen_q <= '0;
      numblk_q <= '0;
      idx_q    <= '0;
      arg_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      clk_on_q <= clk_on_d;
      mode_q   <= mode_d;
      blklen_q <= blklen_d;
      numblk_q <= numblk_d;
      idx_q    <= idx_d;
      arg_q    <= arg_d;
      pend_q   <= pend_d;
    end
  end

  assign clk_on  = clk_on_q;
  assign mode    = mode_q;
  assign blklen  = blklen_q;
  assign numblk  = numblk_q;
  assign cmd_idx = idx_q;
  assign arg     = arg_q;

endmodule

// File: rtl/cardresp_seq.sv
module cardresp_seq
  import cardresp_pkg::*;
#(
  parameter int DEPTH    = 9,
  parameter int CNT_W    = 5,
  parameter int BLKLEN_W = 12,
  parameter int NUMBLK_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         launch_req,
  input  logic                         mode_wr,
  input  logic                         clk_stop,
  input  logic [1:0]                   resp_kind,
  input  logic                         data_en,
  input  logic [BLKLEN_W-1:0]          blklen,
  input  logic [NUMBLK_W-1:0]          numblk,
  input  logic                         card_byte_vld,
  input  logic                         card_done,
  input  logic [CNT_W-1:0]             card_count,
  output logic                         busy,
  output logic                         card_launch,
  output logic                         st_timeout,
  output logic                         st_resp,
  output logic                         irq_cmd,
  output logic                         op_active,
  output logic                         data_arm,
  output logic [BLKLEN_W+NUMBLK_W-1:0] data_bytes,
  output logic                         q_clr,
  output logic                         q_rewind,
  output logic                         q_wr,
  output logic [CNT_W-1:0]             q_wr_idx
);

  localparam int BYTES_W = BLKLEN_W + NUMBLK_W;
  localparam int LIMIT   = 2 * DEPTH;

  logic               busy_q, busy_d;
  logic               launch_q, launch_d;
  logic               tout_q, tout_d;
  logic               resp_q, resp_d;
  logic               irq_q, irq_d;
  logic               act_q, act_d;
  logic               arm_q, arm_d;
  logic [BYTES_W-1:0] bytes_q, bytes_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               finish, short_resp;

  assign finish     = busy_q && card_done;
  assign short_resp = int'(card_count) < min_resp_bytes(resp_kind);

  always_comb begin
    busy_d   = busy_q;
    launch_d = 1'b0;
    tout_d   = tout_q;
    resp_d   = resp_q;
    irq_d    = irq_q;
    act_d    = act_q;
    arm_d    = 1'b0;
    bytes_d  = bytes_q;
    cnt_d    = cnt_q;

    if (clk_stop || mode_wr) act_d = 1'b0;

    if (launch_req) begin
      busy_d   = 1'b1;
      launch_d = 1'b1;
      tout_d   = 1'b0;
      resp_d   = 1'b0;
      irq_d    = 1'b0;
      act_d    = 1'b1;
      cnt_d    = '0;
    end else if (busy_q) begin
      if (card_byte_vld && (cnt_q < CNT_W'(LIMIT))) cnt_d = cnt_q + 1'b1;
      if (card_done) begin
        busy_d = 1'b0;
        irq_d  = 1'b1;
        if (short_resp) begin
          tout_d = 1'b1;
          act_d  = 1'b0;
        end else begin
          resp_d = 1'b1;
          if (data_en) begin
            arm_d   = 1'b1;
            bytes_d = BYTES_W'(numblk) * BYTES_W'(blklen);
            act_d   = 1'b1;
          end else begin
            act_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      launch_q <= 1'b0;
      tout_q   <= 1'b0;
      resp_q   <= 1'b0;
      irq_q    <= 1'b0;
      act_q    <= 1'b0;
      arm_q    <= 1'b0;
      bytes_q  <= '0;
      cnt_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      launch_q <= launch_d;
      tout_q   <= tout_d;
      resp_q   <= resp_d;
      irq_q    <= irq_d;
      act_q    <= act_d;
      arm_q    <= arm_d;
      bytes_q  <= bytes_d;
      cnt_q    <= cnt_d;
    end
  end

  assign q_wr        = busy_q && card_byte_vld && (cnt_q < CNT_W'(LIMIT));
  assign q_wr_idx    = cnt_q;
  assign q_clr       = launch_req || (finish && short_resp);
  assign q_rewind    = finish && !short_resp;
  assign busy        = busy_q;
  assign card_launch = launch_q;
  assign st_timeout  = tout_q;
  assign st_resp     = resp_q;
  assign irq_cmd     = irq_q;
  assign op_active   = act_q;
  assign data_arm    = arm_q;
  assign data_bytes  = bytes_q;

endmodule

// File: rtl/card_resp_capture.sv
module card_resp_capture
  import cardresp_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int DEPTH    = 9,
  parameter int CNT_W    = 5,
  parameter int BLKLEN_W = 12,
  parameter int NUMBLK_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [3:0]                   reg_addr,
  input  logic [15:0]                  reg_wdata,
  output logic [15:0]                  reg_rdata,
  output logic                         card_launch,
  output logic [IDX_W-1:0]             card_index,
  output logic [31:0]                  card_arg,
  input  logic                         card_byte_vld,
  input  logic [7:0]                   card_byte,
  input  logic                         card_done,
  input  logic [CNT_W-1:0]             card_count,
  output logic                         busy,
  output logic                         op_active,
  output logic                         data_arm,
  output logic [BLKLEN_W+NUMBLK_W-1:0] data_bytes
);

  // asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic                clk_on, launch_req, mode_wr, clk_stop;
  logic [REG_W-1:0]    mode;
  logic [BLKLEN_W-1:0] blklen;
  logic [NUMBLK_W-1:0] numblk;
  logic [IDX_W-1:0]    cmd_idx;
  logic [2*REG_W-1:0]  arg;
  logic                st_timeout, st_resp, irq_cmd;
  logic                q_clr, q_rewind, q_wr, rd_adv;
  logic [CNT_W-1:0]    q_wr_idx;
  logic [15:0]         q_rdata;

  cardresp_regs #(
    .IDX_W(IDX_W), .BLKLEN_W(BLKLEN_W), .NUMBLK_W(NUMBLK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .clk_on(clk_on), .mode(mode),
    .blklen(blklen), .numblk(numblk), .cmd_idx(cmd_idx), .arg(arg),
    .launch_req(launch_req), .mode_wr(mode_wr), .clk_stop(clk_stop)
  );

  cardresp_seq #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .BLKLEN_W(BLKLEN_W), .NUMBLK_W(NUMBLK_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync), .launch_req(launch_req), .mode_wr(mode_wr),
    .clk_stop(clk_stop), .resp_kind(mode[1:0]), .data_en(mode[MODE_DATA_BIT]),
    .blklen(blklen), .numblk(numblk), .card_byte_vld(card_byte_vld),
    .card_done(card_done), .card_count(card_count), .busy(busy),
    .card_launch(card_launch), .st_timeout(st_timeout), .st_resp(st_resp),
    .irq_cmd(irq_cmd), .op_active(op_active), .data_arm(data_arm),
    .data_bytes(data_bytes), .q_clr(q_clr), .q_rewind(q_rewind),
    .q_wr(q_wr), .q_wr_idx(q_wr_idx)
  );

  assign rd_adv = reg_rd && (reg_addr == SEL_RESP);

  cardresp_queue #(
    .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_sync), .clr(q_clr), .wr(q_wr), .wr_idx(q_wr_idx),
    .wr_byte(card_byte), .rewind(q_rewind), .rd_adv(rd_adv), .rd_data(q_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_STATUS: begin
        reg_rdata[ST_TOUT_BIT] = st_timeout;
        reg_rdata[ST_CLK_BIT]  = clk_on;
        reg_rdata[ST_RESP_BIT] = st_resp;
      end
      SEL_MODE:   reg_rdata = mode;
      SEL_BLKLEN: reg_rdata = 16'(blklen);
      SEL_NUMBLK: reg_rdata = 16'(numblk);
      SEL_IREQ:   reg_rdata[IREQ_CMD_BIT] = irq_cmd;
      SEL_INDEX:  reg_rdata = 16'(cmd_idx) | 16'(INDEX_TAG);
      SEL_ARG_HI: reg_rdata = arg[2*REG_W-1:REG_W];
      SEL_ARG_LO: reg_rdata = arg[REG_W-1:0];
      SEL_RESP:   reg_rdata = q_rdata;
      default:    reg_rdata = '0;
    endcase
  end

  assign card_index = cmd_idx;
  assign card_arg   = arg;

endmodule

// File: rtl/cardresp_chk.sv
module cardresp_chk
  import cardresp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic       busy,
  input logic       card_launch,
  input logic       card_done,
  input logic       data_arm,
  input logic       op_active
);

  // R3
  launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_launch |=> !card_launch);

  // R11
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_launch |-> busy);

  // R11
  busy_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_addr == SEL_MODE)) |=> !card_launch);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !card_done) |=> busy);

  // R11
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && card_done) |=> !busy);

  // R10
  arm_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_arm |-> op_active);

  // R10
  arm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_arm |=> !data_arm);

endmodule

bind card_resp_capture cardresp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .busy(busy), .card_launch(card_launch), .card_done(card_done),
  .data_arm(data_arm), .op_active(op_active)
);

// File: tb/tb_card_resp_capture.sv
`timescale 1ns/1ps
module tb_card_resp_capture;

  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_MODE = 4'd2,
                         A_BLEN = 4'd3, A_NBLK = 4'd4, A_IREQ = 4'd5,
                         A_IDX  = 4'd6, A_AHI  = 4'd7, A_ALO  = 4'd8,
                         A_RESP = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        card_launch, card_byte_vld, card_done;
  logic [5:0]  card_index;
  logic [31:0] card_arg;
  logic [7:0]  card_byte;
  logic [4:0]  card_count;
  logic        busy, op_active, data_arm;
  logic [27:0] data_bytes;

  int n_tests = 0;
  int n_fail  = 0;
  logic arm_seen;

  always #5 clk = ~clk;

  card_resp_capture dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_launch(card_launch), .card_index(card_index), .card_arg(card_arg),
    .card_byte_vld(card_byte_vld), .card_byte(card_byte), .card_done(card_done),
    .card_count(card_count), .busy(busy), .op_active(op_active),
    .data_arm(data_arm), .data_bytes(data_bytes)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send(input int n, input int cnt, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      card_byte_vld = 1'b1; card_byte = base + 8'(i);
    end
    @(negedge clk);
    card_byte_vld = 1'b0; card_done = 1'b1; card_count = 5'(cnt);
    @(negedge clk);
    card_done = 1'b0;
    arm_seen = data_arm;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_IREQ, v); chk("R1 ireq", v, 0);
    rd(A_RESP, v); chk("R1 resp", v, 0);
    chk("R1 busy", busy, 0);
    chk("R1 op_active", op_active, 0);
  endtask

  task automatic t_index_arg();
    logic [15:0] v;
    wr(A_IDX, 16'h0015); rd(A_IDX, v); chk("R2 index tag", v, 16'h0055);
    wr(A_IDX, 16'hffff); rd(A_IDX, v); chk("R2 index mask", v, 16'h007f);
    wr(A_AHI, 16'h1234); wr(A_ALO, 16'habcd); wr(A_AHI, 16'h5678);
    rd(A_ALO, v); chk("R2 arg low kept", v, 16'habcd);
    rd(A_AHI, v); chk("R2 arg high", v, 16'h5678);
  endtask

  task automatic t_deferred();
    logic [15:0] v;
    wr(A_MODE, 16'hc201);
    chk("R4 no launch clock off", card_launch, 0);
    rd(A_MODE, v); chk("R3 mode mask", v, 16'h0001);
    rd(A_STAT, v); chk("R4 clock off status", v, 0);
    wr(A_CTRL, 16'h0001);
    chk("R4 start launches", card_launch, 1);
    chk("R2 card_arg", card_arg, 32'h5678abcd);
    chk("R2 card_index", card_index, 6'h3f);
    chk("R11 busy at launch", busy, 1);
    send(4, 4, 8'h10);
    chk("R11 busy released", busy, 0);
    rd(A_STAT, v); chk("R7 status good kind1", v, 16'h2100);
    rd(A_IREQ, v); chk("R9 ireq set", v, 16'h0004);
    chk("R10 inactive without data", op_active, 0);
    rd(A_RESP, v); chk("R7 entry0", v, 16'h1110);
    rd(A_RESP, v); chk("R7 entry1", v, 16'h1312);
    rd(A_RESP, v); chk("R7 entry2 empty", v, 16'h0000);
  endtask

  task automatic t_long();
    logic [15:0] v;
    wr(A_MODE, 16'h0002);
    chk("R3 immediate launch", card_launch, 1);
    @(negedge clk);
    chk("R3 launch one cycle", card_launch, 0);
    rd(A_IREQ, v); chk("R9 ireq cleared on launch", v, 0);
    send(16, 16, 8'ha0);
    rd(A_STAT, v); chk("R5 kind2 16 bytes good", v, 16'h2100);
    for (int i = 0; i < 8; i++) begin
      rd(A_RESP, v);
      chk("R7 long entry", v, {8'ha0 + 8'(2*i+1), 8'ha0 + 8'(2*i)});
    end
    rd(A_RESP, v); chk("R8 ninth entry", v, 0);
    rd(A_RESP, v); chk("R8 past end", v, 0);
    rd(A_RESP, v); chk("R8 still zero", v, 0);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    wr(A_MODE, 16'h0001);
    chk("R11 launch", card_launch, 1);
    wr(A_MODE, 16'h0003);
    chk("R11 no relaunch", card_launch, 0);
    rd(A_MODE, v); chk("R11 mode kept", v, 16'h0001);
    chk("R11 still busy", busy, 1);
    send(4, 4, 8'h01);
    chk("R11 idle after done", busy, 0);
    rd(A_STAT, v); chk("R11 completed", v, 16'h2100);
  endtask

  task automatic t_short();
    logic [15:0] v;
    wr(A_MODE, 16'h0002);
    send(10, 10, 8'h40);
    rd(A_STAT, v); chk("R6 timeout status", v, 16'h0102);
    rd(A_RESP, v); chk("R6 queue empty", v, 0);
    chk("R6 op_active low", op_active, 0);
    rd(A_IREQ, v); chk("R9 ireq on timeout", v, 16'h0004);
  endtask

  task automatic t_kind3();
    logic [15:0] v;
    wr(A_MODE, 16'h0003);
    send(3, 3, 8'h70);
    rd(A_STAT, v); chk("R5 kind3 3 bytes short", v, 16'h0102);
    wr(A_MODE, 16'h0003);
    send(4, 4, 8'h70);
    rd(A_STAT, v); chk("R5 kind3 4 bytes good", v, 16'h2100);
    rd(A_RESP, v); chk("R7 kind3 entry0", v, 16'h7170);
  endtask

  task automatic t_kind0();
    logic [15:0] v;
    wr(A_MODE, 16'h0000);
    send(0, 0, 8'h00);
    rd(A_STAT, v); chk("R5 kind0 no bytes good", v, 16'h2100);
  endtask

  task automatic t_data();
    wr(A_BLEN, 16'h0200);
    wr(A_NBLK, 16'h0003);
    wr(A_MODE, 16'h0005);
    send(4, 4, 8'h20);
    chk("R10 arm pulse", arm_seen, 1);
    chk("R10 byte total", data_bytes, 28'h600);
    chk("R10 stays active", op_active, 1);
    @(negedge clk);
    chk("R10 arm one cycle", data_arm, 0);
  endtask

  task automatic t_clock();
    logic [15:0] v;
    wr(A_CTRL, 16'h0002);
    chk("R4 stop drops active", op_active, 0);
    rd(A_STAT, v); chk("R4 clock bit off", v & 16'h0100, 0);
    wr(A_MODE, 16'h0001);
    chk("R4 no launch stopped", card_launch, 0);
    wr(A_CTRL, 16'h0003);
    chk("R4 stop wins", card_launch, 0);
    rd(A_STAT, v); chk("R4 still off", v & 16'h0100, 0);
    wr(A_CTRL, 16'h0001);
    chk("R4 start launches pending", card_launch, 1);
    send(4, 4, 8'h00);
    wr(A_MODE, 16'h0401);
    chk("R4 hold bit no launch", card_launch, 0);
    wr(A_CTRL, 16'h0001);
    chk("R4 hold bit blocks start", card_launch, 0);
    rd(A_MODE, v); chk("R4 hold mode stored", v, 16'h0401);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    card_byte_vld = 1'b0; card_byte = '0; card_done = 1'b0; card_count = '0;
    arm_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_index_arg();
    t_deferred();
    t_long();
    t_busy();
    t_short();
    t_kind3();
    t_kind0();
    t_data();
    t_clock();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule